// File: doc/BRIEF.md
# SPI Memory Slave Serial Front-End

This block is the serial edge of a memory device that answers as a slave on an SPI bus. It watches a select line, a serial clock, a data-in line and a pause line, all sampled into the block's own system clock domain. It collects incoming bits into bytes and hands each finished byte to the command layer with a one-cycle strobe. A flag marks the first byte of a transaction, which is the opcode. A count of the finished bytes is also passed along. In the other direction it shifts out bytes that the command layer supplies. It returns the output pad's enable, which the pad uses to float the line.

Either clock polarity works without a mode input: the serial clock may rest low or rest high between transactions. Input bits are taken when the serial clock rises. Output bits move when it falls. Bytes travel most-significant bit first. The pause line can stop a transfer partway through a byte and later let it resume with nothing lost. The serial clock must run slowly enough, relative to the system clock, for each serial level to be seen over several system cycles.

Top module: `spi_mem_frontend`

## Requirements
- R1: With the serial clock resting low, eight rising serial-clock edges while selected produce one `rx_valid_o` pulse. `rx_byte_o` then holds the bits in arrival order, first bit in bit 7.
- R2: With the serial clock resting high, the same framing holds with no configuration change. The first falling edge after select has no effect on the received data.
- R3: `miso_o` changes only after falling serial-clock edges and presents bit 7 first. The falling edge that follows the eighth rising edge of byte k loads `tx_byte_i` as the next byte, so byte k+1 follows byte k with no gap.
- R4: While `cs_n_i` is high, `miso_oe_o` is 0, no `rx_valid_o` pulse occurs and clock or data activity has no effect.
- R5: Every transaction starts fresh. `byte_cnt_o` is 0 while deselected, and the first completed byte comes with `rx_first_o` = 1 and `byte_cnt_o` = 1. Later bytes come with `rx_first_o` = 0.
- R6: If `cs_n_i` rises after fewer than eight bits of a byte, those bits are dropped with no strobe. The next transaction's first byte is framed from its own first bit.
- R7: When `hold_n_i` goes low while the serial clock is low, `miso_oe_o` goes to 0 and serial-clock edges are ignored. When `hold_n_i` returns high with the clock low, the byte resumes at the bit where it stopped and the output bit is unchanged.
- R8: When `hold_n_i` goes low while the serial clock is high, the pause waits until the clock is low. The falling edge that brings the clock low is still acted on, and `miso_oe_o` stays 1 until then.
- R9: `byte_cnt_o` counts the completed bytes of the current transaction and saturates at 2^CNT_W-1.
- R10: After reset, `miso_oe_o`, `rx_valid_o` and `byte_cnt_o` are 0. `rx_valid_o` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Slave select, active low (asynchronous) |
| sck_i | input | 1 | Serial clock (asynchronous) |
| mosi_i | input | 1 | Serial data in (asynchronous) |
| hold_n_i | input | 1 | Pause request, active low (asynchronous) |
| miso_o | output | 1 | Serial data out value |
| miso_oe_o | output | 1 | Output pad enable; 0 floats the line |
| tx_byte_i | input | DW | Next byte to transmit, taken at the load edge |
| rx_byte_o | output | DW | Last completed received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a completed byte |
| rx_first_o | output | 1 | Marks the strobe of a transaction's first byte |
| byte_cnt_o | output | CNT_W | Completed bytes in this transaction, saturating |

## Verification
Some rules are checked on every cycle: a strobe never follows a deselected sample, the pad enable drops after deselect, the byte count clears on deselect and freezes while paused, and the count saturates. The same every-cycle checks cover the single-cycle strobe and the count value paired with the first-byte flag. Only the bench's scenarios can show the byte contents in both clock polarities. The same holds for gapless output across byte boundaries, a resumed pause with an unchanged bit, and the extra falling edge honoured when a pause is requested with the clock high. Dropping a partial byte is also shown only by a scenario.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  // Pins as sampled from the pads, packed as {cs, sck, mosi, hold}.
  typedef struct packed {
    logic csn;
    logic sck;
    logic mosi;
    logic holdn;
  } spi_pins_t;

  localparam int unsigned PINS_W = $bits(spi_pins_t);

  // Reset value of the synchroniser: deselected, clock low, not held.
  localparam spi_pins_t PINS_IDLE = '{csn: 1'b1, sck: 1'b0, mosi: 1'b0, holdn: 1'b1};

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int unsigned    W       = 4,
  parameter int unsigned    STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic csn_s,
  input  logic sck_s,
  input  logic holdn_s,
  output logic rise_en,
  output logic fall_en,
  output logic paused,
  output logic oe
);

  logic sck_d;
  logic paused_q;
  logic paused_nxt;
  logic oe_q;

  // A pause request only changes state while the clock is low.
  always_comb begin
    if (csn_s)       paused_nxt = 1'b0;
    else if (!sck_s) paused_nxt = !holdn_s;
    else             paused_nxt = paused_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d    <= 1'b0;
      paused_q <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      sck_d    <= sck_s;
      paused_q <= paused_nxt;
      oe_q     <= !csn_s && !paused_nxt;
    end
  end

  assign rise_en = sck_s  && !sck_d && !csn_s && !paused_q;
  assign fall_en = !sck_s &&  sck_d && !csn_s && !paused_q;
  assign paused  = paused_q;
  assign oe      = oe_q;

endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift #(
  parameter int unsigned DW    = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             rise_en,
  input  logic             fall_en,
  input  logic             mosi_s,
  input  logic [DW-1:0]    tx_byte,
  output logic [DW-1:0]    rx_byte,
  output logic             rx_valid,
  output logic             rx_first,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             miso
);

  localparam int unsigned          BW       = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BW-1:0]        BIT_LAST = BW'(DW - 1);
  localparam logic [CNT_W-1:0]     CNT_MAX  = '1;

  logic [BW-1:0]    bit_cnt;
  logic [DW-2:0]    rx_sr;
  logic [DW-1:0]    tx_sr;
  logic             load_pend;

  // Receive side: sample on the rising edge.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bit_cnt   <= '0;
      rx_sr     <= '0;
      rx_valid  <= 1'b0;
      rx_first  <= 1'b0;
      byte_cnt  <= '0;
      if (rst) rx_byte <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (rise_en) begin
        if (bit_cnt == BIT_LAST) begin
          bit_cnt  <= '0;
          rx_byte  <= {rx_sr, mosi_s};
          rx_valid <= 1'b1;
          rx_first <= (byte_cnt == '0);
          if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          rx_sr   <= {rx_sr[DW-3:0], mosi_s};
        end
      end
    end
  end

  // Transmit side: move on the falling edge; reload after a full byte.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tx_sr     <= '0;
      load_pend <= 1'b0;
    end else begin
      if (rise_en && bit_cnt == BIT_LAST) begin
        load_pend <= 1'b1;
      end else if (fall_en) begin
        if (load_pend) begin
          tx_sr     <= tx_byte;
          load_pend <= 1'b0;
        end else begin
          tx_sr <= {tx_sr[DW-2:0], 1'b0};
        end
      end
    end
  end

  assign miso = tx_sr[DW-1];

endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend #(
  parameter int unsigned DW          = 8,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n_i,
  input  logic             sck_i,
  input  logic             mosi_i,
  input  logic             hold_n_i,
  output logic             miso_o,
  output logic             miso_oe_o,
  input  logic [DW-1:0]    tx_byte_i,
  output logic [DW-1:0]    rx_byte_o,
  output logic             rx_valid_o,
  output logic             rx_first_o,
  output logic [CNT_W-1:0] byte_cnt_o
);

  import spi_fe_pkg::*;

  spi_pins_t pins_raw;
  spi_pins_t pins_s;
  logic      csn_s;
  logic      rise_en;
  logic      fall_en;
  logic      paused;

  assign pins_raw = '{csn: cs_n_i, sck: sck_i, mosi: mosi_i, holdn: hold_n_i};

  spi_fe_sync #(
    .W       (PINS_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PINS_IDLE)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_raw),
    .q   (pins_s)
  );

  assign csn_s = pins_s.csn;

  spi_fe_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .csn_s   (csn_s),
    .sck_s   (pins_s.sck),
    .holdn_s (pins_s.holdn),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .paused  (paused),
    .oe      (miso_oe_o)
  );

  spi_fe_shift #(
    .DW    (DW),
    .CNT_W (CNT_W)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .clr      (csn_s),
    .rise_en  (rise_en),
    .fall_en  (fall_en),
    .mosi_s   (pins_s.mosi),
    .tx_byte  (tx_byte_i),
    .rx_byte  (rx_byte_o),
    .rx_valid (rx_valid_o),
    .rx_first (rx_first_o),
    .byte_cnt (byte_cnt_o),
    .miso     (miso_o)
  );

endmodule

// File: rtl/spi_fe_chk.sv
module spi_fe_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             csn_s,
  input logic             paused,
  input logic             rx_valid,
  input logic             rx_first,
  input logic             oe,
  input logic [CNT_W-1:0] byte_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_NO_STROBE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !$past(csn_s)); // R4

  AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> !oe); // R4

  AST_CNT_CLEARED_IDLE: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> byte_cnt == '0); // R5

  AST_FIRST_IS_ONE: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_first) |-> byte_cnt == CNT_W'(1)); // R5

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (paused && !csn_s) |=> ($stable(byte_cnt) && !rx_valid)); // R7

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (byte_cnt == CNT_MAX && !csn_s) |=> byte_cnt == CNT_MAX); // R9

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R10

endmodule

bind spi_mem_frontend spi_fe_chk #(.CNT_W(CNT_W)) u_fe_chk (
  .clk      (clk),
  .rst      (rst),
  .csn_s    (csn_s),
  .paused   (paused),
  .rx_valid (rx_valid_o),
  .rx_first (rx_first_o),
  .oe       (miso_oe_o),
  .byte_cnt (byte_cnt_o)
);

// File: tb/test_spi_mem_frontend.sv
module test_spi_mem_frontend;

  localparam int CW   = 3;
  localparam int MAXC = (1 << CW) - 1;
  localparam int HP   = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          csn = 1'b1;
  logic          sck = 1'b0;
  logic          mosi = 1'b0;
  logic          holdn = 1'b1;
  logic          miso_o, miso_oe_o, rx_valid_o, rx_first_o;
  logic [7:0]    rx_byte_o, tx_byte_i;
  logic [CW-1:0] byte_cnt_o;

  int tests = 0;
  int fails = 0;
  int n = 0;
  int exp_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(int k);
    return 8'(8'h5A ^ (k * 19));
  endfunction

  // Command layer stand-in: next byte depends on bytes completed so far.
  assign tx_byte_i = pat(int'(byte_cnt_o));

  spi_mem_frontend #(.DW(8), .CNT_W(CW)) i_spi_mem_frontend (
    .clk(clk), .rst(rst), .cs_n_i(csn), .sck_i(sck), .mosi_i(mosi),
    .hold_n_i(holdn), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .tx_byte_i(tx_byte_i), .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o),
    .rx_first_o(rx_first_o), .byte_cnt_o(byte_cnt_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_c(input int c);
    repeat (c) @(negedge clk);
  endtask

  // Per-clock comparison of strobes against the model queue.
  always @(negedge clk) begin
    if (!rst && rx_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4/R6 unexpected strobe", int'(rx_byte_o), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(rx_byte_o) == (e & 255), "R1/R2 rx byte", int'(rx_byte_o), e & 255);
        check(int'(rx_first_o) == ((e >> 12) & 1), "R5 first flag", int'(rx_first_o), (e >> 12) & 1);
        check(int'(byte_cnt_o) == ((e >> 8) & 15), "R9 byte count", int'(byte_cnt_o), (e >> 8) & 15);
      end
    end
  end

  task automatic start(input bit m3);
    sck = m3; wait_c(HP);
    csn = 1'b0; n = 0; wait_c(HP);
  endtask

  task automatic stop();
    if (sck) begin
      sck = 1'b0; wait_c(HP);
      sck = 1'b1; wait_c(HP);
    end
    csn = 1'b1; wait_c(2 * HP);
    check(miso_oe_o == 1'b0, "R4 oe off after deselect", int'(miso_oe_o), 0);
    check(exp_q.size() == 0, "R1 missing strobe", exp_q.size(), 0);
    check(byte_cnt_o == '0, "R5 count cleared", int'(byte_cnt_o), 0);
  endtask

  // Sends nb bits of d (MSB first). hold_at: bit index of a pause; hold_hi: request it with sck high.
  task automatic xfer(input logic [7:0] d, input int nb, input int hold_at, input bit hold_hi);
    int k;
    logic [7:0] tx_exp;
    k = n;
    tx_exp = pat(k < MAXC ? k : MAXC);
    for (int i = 7; i >= 8 - nb; i--) begin
      if (sck) begin sck = 1'b0; wait_c(HP); end
      mosi = d[i];
      if (hold_at == i && !hold_hi) begin
        holdn = 1'b0; wait_c(HP);
        check(miso_oe_o == 1'b0, "R7 oe off in pause", int'(miso_oe_o), 0);
        mosi = ~d[i];
        sck = 1'b1; wait_c(HP);
        sck = 1'b0; wait_c(HP);
        mosi = d[i];
        holdn = 1'b1; wait_c(HP);
        check(miso_oe_o == 1'b1, "R7 oe back after pause", int'(miso_oe_o), 1);
      end
      if (k >= 1)
        check(miso_o == tx_exp[i], "R3 tx bit", int'(miso_o), int'(tx_exp[i]));
      if (i == 0) begin
        exp_q.push_back(((k == 0) ? 4096 : 0) + (((k + 1) < MAXC ? (k + 1) : MAXC) << 8) + int'(d));
        n++;
      end
      sck = 1'b1; wait_c(HP);
      if (hold_at == i && hold_hi && i > 0) begin
        holdn = 1'b0; wait_c(HP);
        check(miso_oe_o == 1'b1, "R8 pause waits for low clock", int'(miso_oe_o), 1);
        sck = 1'b0; wait_c(HP);
        check(miso_oe_o == 1'b0, "R8 pause taken after fall", int'(miso_oe_o), 0);
        mosi = ~d[i-1];
        sck = 1'b1; wait_c(HP);
        sck = 1'b0; wait_c(HP);
        holdn = 1'b1; wait_c(HP);
      end
    end
  endtask

  initial begin
    wait_c(5);
    rst = 1'b0;
    wait_c(2);
    // R10 reset state
    check(miso_oe_o == 1'b0, "R10 oe after reset", int'(miso_oe_o), 0);
    check(rx_valid_o == 1'b0, "R10 strobe after reset", int'(rx_valid_o), 0);
    check(byte_cnt_o == '0, "R10 count after reset", int'(byte_cnt_o), 0);

    // R4: activity while deselected is ignored
    for (int i = 0; i < 16; i++) begin
      mosi = i[0]; sck = 1'b1; wait_c(HP);
      sck = 1'b0; wait_c(HP);
      check(miso_oe_o == 1'b0, "R4 oe while deselected", int'(miso_oe_o), 0);
    end
    check(byte_cnt_o == '0, "R4 count while deselected", int'(byte_cnt_o), 0);

    // R1 / R3: clock rests low, read stream
    start(0);
    xfer(8'h03, 8, -1, 0);
    xfer(8'hA5, 8, -1, 0);
    xfer(8'h3C, 8, -1, 0);
    xfer(8'hFF, 8, -1, 0);
    stop();

    // R2: clock rests high
    start(1);
    xfer(8'h0B, 8, -1, 0);
    xfer(8'h81, 8, -1, 0);
    xfer(8'h7E, 8, -1, 0);
    stop();

    // R6: partial byte dropped, R5: next transaction starts fresh
    start(0);
    xfer(8'hF0, 5, -1, 0);
    stop();
    start(0);
    xfer(8'h9C, 8, -1, 0);
    xfer(8'h11, 8, -1, 0);
    stop();

    // R7: pause requested with clock low
    start(0);
    xfer(8'h02, 8, -1, 0);
    xfer(8'hC3, 8, 4, 0);
    xfer(8'h5A, 8, 0, 0);
    stop();

    // R8: pause requested with clock high
    start(1);
    xfer(8'h06, 8, -1, 0);
    xfer(8'h96, 8, 5, 1);
    xfer(8'h2D, 8, -1, 0);
    stop();

    // R9: count saturation
    start(0);
    for (int b = 0; b < 9; b++) xfer(8'(8'h40 + b * 7), 8, -1, 0);
    wait_c(HP);
    check(int'(byte_cnt_o) == MAXC, "R9 saturated count", int'(byte_cnt_o), MAXC);
    stop();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule